// File: doc/BRIEF.md
# Oversampled Bit Synchronizer with Lead/Lag Phase Correction

This block recovers bit timing from a slow serial stream. It samples the stream on a tick that runs eight times faster than the bit rate. A typical setting is a 100-baud stream and an 800 Hz tick, which can be derived from a 2.4576 MHz reference. The raw line level is inverted before any other use. After reset or a restart, the block waits for a level change and then requires the new level to stay unchanged for three further ticks. Only then does it lock into a repeating cycle of eight tick states. In the first state of that cycle it issues the current sample as a received bit.

While locked, the block watches for level changes at four points in the cycle. Changes seen two or three ticks after the sampling tick mean that the local cycle lags the stream. These add to a bounded lead/lag counter. When that counter reaches its upper bound, it reloads to the midpoint and one cycle state is skipped. Changes seen five or six ticks after the sampling tick subtract from the counter. When it reaches its lower bound, it reloads to the midpoint and the current state is repeated. The block passes bits downstream and does no character decoding or framing.

Top module: `bitsync_phase`

## Requirements
- R1: `bit_o` reports the inverse of the `data_i` level at the sampling tick: `data_i` = 0 gives a received bit of 1.
- R2: After reset or restart the previous sample is 0. A steady `data_i` = 1 therefore looks like no change, and no bit is ever issued.
- R3: Locking starts with a tick whose inverted sample differs from the previous tick's sample. The next three ticks must each see no change. A change on any of those three ticks returns the block to hunting. The first bit is issued on the fourth tick after the edge tick.
- R4: Once locked, bits are issued every eight ticks when no correction happens. `bit_valid_o` is high for exactly one clock, on the clock after the sampling tick. `bit_o` holds its value between strobes.
- R5: A change seen on the second or third tick after a sampling tick adds one to the lead/lag counter, which starts at 8. When an add brings the counter to 16, it reloads to 8 and the following cycle state is skipped, so that bit interval is seven ticks.
- R6: A change seen on the fifth or sixth tick after a sampling tick subtracts one from the counter. When a subtract brings it to 0, it reloads to 8 and the current cycle state is repeated, so that bit interval is nine ticks.
- R7: A change seen on the sampling tick, or on the first, fourth or seventh tick after it, has no effect on timing.
- R8: `restart_i` acts synchronously and takes priority over `tick_i`. It sets the block to hunting, clears the previous sample and the outputs to 0, and reloads the counter to 8. Asynchronous reset (`rst_n` low) gives the same state.
- R9: With `tick_i` low, nothing advances: no strobe is issued and the previous sample does not follow `data_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversampling tick, one clock wide, eight per bit |
| restart_i | input | 1 | Synchronous return to hunting |
| data_i | input | 1 | Raw serial line level, synchronous to `clk` |
| bit_valid_o | output | 1 | One-clock strobe for a received bit |
| bit_o | output | 1 | Received bit value, held until the next strobe |

## Verification
The assertions assume four things about the inputs:
- `data_i` is already synchronous to `clk`.
- `tick_i` and `restart_i` are single-clock, synchronous pulses.
- Several clocks separate ticks.
- Timing is judged only at tick clocks.

The stimulus keeps within these assumptions. It drives every input on the falling clock edge and pulses `tick_i` for one clock in every four. It changes `data_i` away from ticks only in the test that checks that such changes are ignored. A behavioural model in the bench predicts both outputs on every clock. Directed runs place line changes on chosen cycle states, so the seven-tick and nine-tick corrected intervals appear at known tick numbers.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

    // Timing event raised by the sequencer toward the lead/lag counter
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_LEAD = 2'd1,
        EV_LAG  = 2'd2
    } phase_evt_e;

    // Correction returned by the counter for the current tick
    typedef struct packed {
        logic skip;
        logic rep;
    } phase_cmd_t;

endpackage

// File: rtl/bsync_sampler.sv
module bsync_sampler #(
    parameter bit INVERT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic tick_i,
    input  logic data_i,
    output logic cur_o,
    output logic changed_o
);

    typedef struct packed {
        logic prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        cur_o = data_i ^ INVERT;
        changed_o = (cur_o != smp_q.prev);
        if (restart_i) begin
            smp_d.prev = 1'b0;
        end else if (tick_i) begin
            smp_d.prev = cur_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

endmodule

// File: rtl/bsync_phase_acc.sv
module bsync_phase_acc
    import bsync_pkg::*;
#(
    parameter int PH_MAX = 16,
    parameter int PH_MID = 8,
    parameter int PH_MIN = 0,
    parameter int CW     = $clog2(PH_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  phase_evt_e    evt_i,
    output phase_cmd_t    cmd_o,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] C_MID     = CW'(PH_MID);
    localparam logic [CW-1:0] C_TOP_PRE = CW'(PH_MAX - 1);
    localparam logic [CW-1:0] C_BOT_PRE = CW'(PH_MIN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        cmd_o = '0;
        unique case (evt_i)
            EV_LEAD: begin
                if (acc_q.cnt == C_TOP_PRE) begin
                    acc_d.cnt  = C_MID;
                    cmd_o.skip = 1'b1;
                end else begin
                    acc_d.cnt = acc_q.cnt + 1'b1;
                end
            end
            EV_LAG: begin
                if (acc_q.cnt == C_BOT_PRE) begin
                    acc_d.cnt = C_MID;
                    cmd_o.rep = 1'b1;
                end else begin
                    acc_d.cnt = acc_q.cnt - 1'b1;
                end
            end
            default: begin
            end
        endcase
        if (restart_i) begin
            acc_d.cnt = C_MID;
            cmd_o     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q.cnt <= C_MID;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign cnt_o = acc_q.cnt;

endmodule

// File: rtl/bsync_seq.sv
module bsync_seq
    import bsync_pkg::*;
#(
    parameter int SW        = 4,
    parameter int ST_SAMPLE = 4,
    parameter int ST_LAST   = 11,
    parameter int ST_LEAD_A = 6,
    parameter int ST_LAG_A  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          tick_i,
    input  logic          cur_i,
    input  logic          changed_i,
    input  phase_cmd_t    cmd_i,
    output phase_evt_e    evt_o,
    output logic [SW-1:0] state_o,
    output logic          valid_o,
    output logic          bit_o
);

    localparam logic [SW-1:0] S_HUNT   = '0;
    localparam logic [SW-1:0] S_SAMPLE = SW'(ST_SAMPLE);
    localparam logic [SW-1:0] S_LAST   = SW'(ST_LAST);
    localparam logic [SW-1:0] S_LEAD_A = SW'(ST_LEAD_A);
    localparam logic [SW-1:0] S_LEAD_B = SW'(ST_LEAD_A + 1);
    localparam logic [SW-1:0] S_LAG_A  = SW'(ST_LAG_A);
    localparam logic [SW-1:0] S_LAG_B  = SW'(ST_LAG_A + 1);

    typedef struct packed {
        logic [SW-1:0] state;
        logic          valid;
        logic          bitv;
    } seq_t;

    seq_t seq_d, seq_q;

    logic in_lead;
    logic in_lag;

    assign in_lead = (seq_q.state == S_LEAD_A) || (seq_q.state == S_LEAD_B);
    assign in_lag  = (seq_q.state == S_LAG_A)  || (seq_q.state == S_LAG_B);

    // Event toward the counter: only on a tick, only with a change
    always_comb begin
        evt_o = EV_NONE;
        if (tick_i && !restart_i && changed_i) begin
            if (in_lead) begin
                evt_o = EV_LEAD;
            end else if (in_lag) begin
                evt_o = EV_LAG;
            end
        end
    end

    always_comb begin
        seq_d       = seq_q;
        seq_d.valid = 1'b0;
        if (tick_i) begin
            if (seq_q.state == S_HUNT) begin
                seq_d.state = changed_i ? SW'(1) : S_HUNT;
            end else if (seq_q.state < S_SAMPLE) begin
                seq_d.state = changed_i ? S_HUNT : seq_q.state + SW'(1);
            end else begin
                seq_d.state = (seq_q.state == S_LAST) ? S_SAMPLE : seq_q.state + SW'(1);
                if (seq_q.state == S_SAMPLE) begin
                    seq_d.valid = 1'b1;
                    seq_d.bitv  = cur_i;
                end
                if (cmd_i.skip) begin
                    seq_d.state = seq_q.state + SW'(2);
                end
                if (cmd_i.rep) begin
                    seq_d.state = seq_q.state;
                end
            end
        end
        if (restart_i) begin
            seq_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o = seq_q.state;
    assign valid_o = seq_q.valid;
    assign bit_o   = seq_q.bitv;

endmodule

// File: rtl/bitsync_phase.sv
module bitsync_phase
    import bsync_pkg::*;
#(
    parameter int CONFIRM   = 3,
    parameter int BIT_TICKS = 8,
    parameter int LEAD_OFS  = 2,
    parameter int LAG_OFS   = 5,
    parameter int PH_MAX    = 16,
    parameter int PH_MID    = 8,
    parameter int PH_MIN    = 0,
    parameter bit INVERT    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic restart_i,
    input  logic data_i,
    output logic bit_valid_o,
    output logic bit_o
);

    localparam int ST_SAMPLE = CONFIRM + 1;
    localparam int ST_LAST   = ST_SAMPLE + BIT_TICKS - 1;
    localparam int ST_LEAD_A = ST_SAMPLE + LEAD_OFS;
    localparam int ST_LAG_A  = ST_SAMPLE + LAG_OFS;
    localparam int SW        = $clog2(ST_LAST + 1);
    localparam int CW        = $clog2(PH_MAX + 1);

    logic          samp_cur;
    logic          samp_changed;
    phase_evt_e    phase_evt;
    phase_cmd_t    phase_cmd;
    logic [CW-1:0] phase_cnt;
    logic [SW-1:0] seq_state;

    bsync_sampler #(
        .INVERT (INVERT)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart_i),
        .tick_i    (tick_i),
        .data_i    (data_i),
        .cur_o     (samp_cur),
        .changed_o (samp_changed)
    );

    bsync_phase_acc #(
        .PH_MAX (PH_MAX),
        .PH_MID (PH_MID),
        .PH_MIN (PH_MIN),
        .CW     (CW)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart_i),
        .evt_i     (phase_evt),
        .cmd_o     (phase_cmd),
        .cnt_o     (phase_cnt)
    );

    bsync_seq #(
        .SW        (SW),
        .ST_SAMPLE (ST_SAMPLE),
        .ST_LAST   (ST_LAST),
        .ST_LEAD_A (ST_LEAD_A),
        .ST_LAG_A  (ST_LAG_A)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart_i),
        .tick_i    (tick_i),
        .cur_i     (samp_cur),
        .changed_i (samp_changed),
        .cmd_i     (phase_cmd),
        .evt_o     (phase_evt),
        .state_o   (seq_state),
        .valid_o   (bit_valid_o),
        .bit_o     (bit_o)
    );

endmodule

// File: rtl/bitsync_phase_chk.sv
module bitsync_phase_chk #(
    parameter int SW        = 4,
    parameter int CW        = 5,
    parameter int CONFIRM   = 3,
    parameter int ST_SAMPLE = 4,
    parameter int ST_LAST   = 11,
    parameter int ST_LEAD_A = 6,
    parameter int ST_LAG_A  = 9,
    parameter int PH_MAX    = 16,
    parameter int PH_MID    = 8,
    parameter int PH_MIN    = 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_i,
    input logic          restart_i,
    input logic          data_i,
    input logic          bit_valid_o,
    input logic          bit_o,
    input logic [SW-1:0] state,
    input logic [CW-1:0] cnt,
    input logic          changed
);

    p_strobe_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> ($past(tick_i) && $past(state) == SW'(ST_SAMPLE)));

    p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |=> !bit_valid_o);

    p_cycle_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !restart_i && state == SW'(ST_LAST)) |=> state == SW'(ST_SAMPLE));

    p_bit_inverted_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> (bit_o == !$past(data_i)));

    p_confirm_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !restart_i && state >= SW'(1) && state <= SW'(CONFIRM) && changed)
        |=> state == '0);

    p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !restart_i && state == SW'(ST_LEAD_A) && changed && cnt == CW'(PH_MAX - 1))
        |=> (state == SW'(ST_LEAD_A + 2) && cnt == CW'(PH_MID)));

    p_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !restart_i && state == SW'(ST_LAG_A + 1) && changed && cnt == CW'(PH_MIN + 1))
        |=> (state == SW'(ST_LAG_A + 1) && cnt == CW'(PH_MID)));

    p_cnt_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > CW'(PH_MIN)) && (cnt < CW'(PH_MAX)));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (state == '0 && cnt == CW'(PH_MID) && !bit_valid_o && !bit_o));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> ($stable(state) && $stable(cnt) && !bit_valid_o));

endmodule

bind bitsync_phase bitsync_phase_chk #(
    .SW        (SW),
    .CW        (CW),
    .CONFIRM   (CONFIRM),
    .ST_SAMPLE (ST_SAMPLE),
    .ST_LAST   (ST_LAST),
    .ST_LEAD_A (ST_LEAD_A),
    .ST_LAG_A  (ST_LAG_A),
    .PH_MAX    (PH_MAX),
    .PH_MID    (PH_MID),
    .PH_MIN    (PH_MIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .restart_i   (restart_i),
    .data_i      (data_i),
    .bit_valid_o (bit_valid_o),
    .bit_o       (bit_o),
    .state       (seq_state),
    .cnt         (phase_cnt),
    .changed     (samp_changed)
);

// File: tb/bitsync_phase_tb_top.sv
module bitsync_phase_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic restart_i = 1'b0;
    logic data_i = 1'b1;
    logic bit_valid_o;
    logic bit_o;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    bitsync_phase dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .restart_i   (restart_i),
        .data_i      (data_i),
        .bit_valid_o (bit_valid_o),
        .bit_o       (bit_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on every rising edge
    int m_state = 0;
    int m_prev  = 0;
    int m_cnt   = 8;
    int m_valid = 0;
    int m_bit   = 0;

    always @(posedge clk) begin : ref_model
        int cur;
        int nxt;
        bit ch;
        if (!rst_n || restart_i) begin
            m_state = 0; m_prev = 0; m_cnt = 8; m_valid = 0; m_bit = 0;
        end else begin
            m_valid = 0;
            if (tick_i) begin
                cur = data_i ? 0 : 1;
                ch  = (cur != m_prev);
                if (m_state == 0) begin
                    m_state = ch ? 1 : 0;
                end else if (m_state <= 3) begin
                    m_state = ch ? 0 : m_state + 1;
                end else begin
                    nxt = (m_state == 11) ? 4 : m_state + 1;
                    if (m_state == 4) begin
                        m_valid = 1;
                        m_bit   = cur;
                    end
                    if (ch && (m_state == 6 || m_state == 7)) begin
                        m_cnt++;
                        if (m_cnt == 16) begin
                            m_cnt = 8;
                            nxt   = m_state + 2;
                        end
                    end
                    if (ch && (m_state == 9 || m_state == 10)) begin
                        m_cnt--;
                        if (m_cnt == 0) begin
                            m_cnt = 8;
                            nxt   = m_state;
                        end
                    end
                    m_state = nxt;
                end
                m_prev = cur;
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(bit_valid_o === m_valid[0], "R4", bit_valid_o, m_valid);
            chk(bit_o === m_bit[0], "R1", bit_o, m_bit);
        end
    end

    task automatic do_tick(input logic d, output logic v, output logic b);
        @(negedge clk);
        data_i = d;
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        v = bit_valid_o;
        b = bit_o;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart_i = 1'b1;
        @(negedge clk);
        restart_i = 1'b0;
        chk(bit_valid_o == 1'b0, "R8", bit_valid_o, 0);
        chk(bit_o == 1'b0, "R8", bit_o, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        logic v;
        logic b;
        int   nstrobe;
        int   expv;
        logic d;
        bit   pat [0:5];
        pat = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bit_valid_o == 1'b0, "R8", bit_valid_o, 0);
        chk(bit_o == 1'b0, "R8", bit_o, 0);

        // R2: steady high line never starts a lock
        nstrobe = 0;
        for (int t = 0; t < 40; t++) begin
            do_tick(1'b1, v, b);
            if (v) nstrobe++;
        end
        chk(nstrobe == 0, "R2", nstrobe, 0);

        // R3, R1, R4, R7: aligned stream, line changes on the fourth tick after sampling
        for (int t = 0; t < 48; t++) begin
            d = pat[t / 8];
            do_tick(d, v, b);
            expv = ((t % 8) == 4) ? 1 : 0;
            chk(v == expv[0], "R3", v, expv);
            if (expv != 0) chk(b == !d, "R1", b, !d);
        end

        // R3: change during confirmation returns to hunting
        do_restart();
        for (int t = 0; t < 4; t++) do_tick(1'b1, v, b);
        do_tick(1'b0, v, b);
        do_tick(1'b0, v, b);
        nstrobe = 0;
        for (int t = 0; t < 20; t++) begin
            do_tick(1'b1, v, b);
            if (v) nstrobe++;
        end
        chk(nstrobe == 0, "R3", nstrobe, 0);

        // R5: changes at the lead checks until the counter saturates, one seven-tick bit
        do_restart();
        for (int t = 0; t < 2; t++) do_tick(1'b1, v, b);
        for (int t = 0; t <= 44; t++) begin
            d = (t >= 6 && t <= 30 && ((t - 6) % 8) == 0) ? 1'b1 : 1'b0;
            do_tick(d, v, b);
            expv = (t == 4 || t == 12 || t == 20 || t == 28 || t == 35 || t == 43) ? 1 : 0;
            chk(v == expv[0], "R5", v, expv);
        end

        // R6: changes at the lag checks until the counter empties, one nine-tick bit
        do_restart();
        for (int t = 0; t < 2; t++) do_tick(1'b1, v, b);
        for (int t = 0; t <= 47; t++) begin
            d = (t >= 9 && t <= 33 && ((t - 9) % 8) == 0) ? 1'b1 : 1'b0;
            do_tick(d, v, b);
            expv = (t == 4 || t == 12 || t == 20 || t == 28 || t == 37 || t == 45) ? 1 : 0;
            chk(v == expv[0], "R6", v, expv);
        end

        // R9: line moves without ticks; nothing advances
        nstrobe = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            data_i = c[0];
            if (bit_valid_o) nstrobe++;
        end
        chk(nstrobe == 0, "R9", nstrobe, 0);
        for (int t = 0; t < 6; t++) begin
            do_tick(1'b0, v, b);
            expv = (t == 5) ? 1 : 0;
            chk(v == expv[0], "R9", v, expv);
        end

        // R8: restart wins over a simultaneous tick and clears the previous sample
        @(negedge clk);
        restart_i = 1'b1;
        tick_i    = 1'b1;
        data_i    = 1'b0;
        @(negedge clk);
        restart_i = 1'b0;
        tick_i    = 1'b0;
        chk(bit_valid_o == 1'b0, "R8", bit_valid_o, 0);
        for (int t = 0; t < 5; t++) begin
            do_tick(1'b0, v, b);
            expv = (t == 4) ? 1 : 0;
            chk(v == expv[0], "R8", v, expv);
            if (expv != 0) chk(b == 1'b1, "R8", b, 1);
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule